// File: doc/BRIEF.md
# Coarse-Fine Sine-Cosine Mixer

This block mixes a stream of real samples with a locally generated complex tone. Each input beat carries a sample and a phase word. The block turns the phase word into a high-resolution sine and cosine pair and returns the sample multiplied by both, as an in-phase and a quadrature output. A phase accumulator upstream sets the tone frequency. Filtering and decimation happen downstream.

The angle is built from two small tables. The coarse part of the phase addresses a table that covers one eighth of a turn. Folding maps that eighth onto the full circle: the address is mirrored, sine and cosine are swapped, and the sign is set from the quadrant. The fine part addresses a second table that holds the sine and cosine of a small signed offset angle. Four multiplies apply the angle-sum identity to the two lookups. Two further multiplies apply the sample to the result.

Both streams use valid/ready handshakes. A beat moves on a rising edge where its valid and ready are both high. The whole pipeline advances only when the output register is empty or is being taken, so back-pressure from `out_ready` reaches `in_ready` in the same cycle. Once `out_valid` is high, the output beat stays unchanged until it is accepted.

Top module: `scm_mixer`

## Requirements
- R1: The phase word is read from the MSB down, in this order: 3 octant bits, OCT_AW coarse bits, then FINE_W fine bits. The remaining PHASE_W-3-OCT_AW-FINE_W low bits have no effect. The angle is θ = 2π·U/2^(3+OCT_AW+FINE_W), where U is the upper 3+OCT_AW+FINE_W bits read as an unsigned number.
- R2: `out_i` (signed, SAMPLE_W+1 bits) is within 2 LSB of x·cos θ, where x is the signed sample. This holds for TRIG_W of at least 16.
- R3: `out_q` (signed, SAMPLE_W+1 bits) is within 2 LSB of −x·sin θ. This holds for TRIG_W of at least 16.
- R4: With `out_ready` held high, a beat accepted at rising edge k is presented with `out_valid` high from rising edge k+3.
- R5: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. With `out_ready` held high, one beat is accepted every cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_i` and `out_q` hold their values.
- R7: Every accepted beat produces exactly one output beat, and outputs come out in acceptance order.
- R8: While `rst_n` is low, and at the first edge after its release, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_phase | input | PHASE_W | Phase word, MSB-aligned |
| in_sample | input | SAMPLE_W | Signed real sample |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_i | output | SAMPLE_W+1 | Signed in-phase product |
| out_q | output | SAMPLE_W+1 | Signed quadrature product |

## Verification
The bench builds the block with OCT_AW=4, FINE_W=4, PHASE_W=13, SAMPLE_W=12 and TRIG_W=16. This gives an 11-bit angle and 2 ignored low bits. A streaming sweep over all 8192 phase words reaches every octant, every mirrored coarse entry and every fine entry. It also shows that the ignored bits change nothing. Full-scale positive and negative samples cover the edges of the output range. A second pass uses pseudo-random gaps on both handshakes, which exercises stalls, hold behaviour and ordering.

// File: rtl/scm_pkg.sv
`timescale 1ns/1ps
package scm_pkg;

  localparam real SCM_TWO_PI = 6.283185307179586;

  // Scale a value in [-1,1] to a signed integer of width w, rounding to nearest.
  function automatic int scm_quantize(input real v, input int w);
    real amp;
    amp = real'((1 << (w - 1)) - 1);
    return int'($floor(v * amp + 0.5));
  endfunction

endpackage

// File: rtl/scm_trig_rom.sv
`timescale 1ns/1ps
// Table of sin/cos pairs. Entry k holds the angle 2*pi*(k+OFS)/2^DEN_LOG2.
// Each word packs both values, so one memory serves one lookup.
module scm_trig_rom #(
  parameter int  AW       = 9,
  parameter int  TRIG_W   = 18,
  parameter int  DEN_LOG2 = 12,
  parameter real OFS      = 0.5
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic [AW-1:0]            addr,
  output logic signed [TRIG_W-1:0] sin_o,
  output logic signed [TRIG_W-1:0] cos_o
);
  import scm_pkg::*;

  localparam int DEPTH = 1 << AW;
  localparam int WW    = 2 * TRIG_W;

  logic [WW-1:0] tab [DEPTH];
  logic [WW-1:0] rd_q;

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      real ang;
      ang = SCM_TWO_PI * (real'(k) + OFS) / (2.0 ** DEN_LOG2);
      tab[k] = {TRIG_W'(scm_quantize($sin(ang), TRIG_W)),
                TRIG_W'(scm_quantize($cos(ang), TRIG_W))};
    end
  end

  always_ff @(posedge clk) begin
    if (en) rd_q <= tab[addr];
  end

  assign sin_o = rd_q[WW-1:TRIG_W];
  assign cos_o = rd_q[TRIG_W-1:0];

endmodule

// File: rtl/scm_octant_map.sv
`timescale 1ns/1ps
// Unfold a first-octant lookup onto the whole circle.
module scm_octant_map #(
  parameter int TRIG_W = 18
) (
  input  logic [1:0]               quad,
  input  logic                     half,
  input  logic signed [TRIG_W-1:0] rom_s,
  input  logic signed [TRIG_W-1:0] rom_c,
  output logic signed [TRIG_W-1:0] sin_o,
  output logic signed [TRIG_W-1:0] cos_o
);
  logic signed [TRIG_W-1:0] s0, c0;

  always_comb begin
    // Odd octant: the mirrored entry holds the complementary angle.
    s0 = half ? rom_c : rom_s;
    c0 = half ? rom_s : rom_c;
    unique case (quad)
      2'd0: begin sin_o = s0;  cos_o = c0;  end
      2'd1: begin sin_o = c0;  cos_o = -s0; end
      2'd2: begin sin_o = -s0; cos_o = -c0; end
      default: begin sin_o = -c0; cos_o = s0; end
    endcase
  end

endmodule

// File: rtl/scm_angle_sum.sv
`timescale 1ns/1ps
// sin(a+d), cos(a+d) from the two lookups: one product register stage,
// then one register stage for rounding adders with saturation.
module scm_angle_sum #(
  parameter int TRIG_W = 18
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic signed [TRIG_W-1:0] sin_a,
  input  logic signed [TRIG_W-1:0] cos_a,
  input  logic signed [TRIG_W-1:0] sin_d,
  input  logic signed [TRIG_W-1:0] cos_d,
  output logic signed [TRIG_W-1:0] sin_o,
  output logic signed [TRIG_W-1:0] cos_o
);
  localparam int PW = 2 * TRIG_W;
  localparam int SW = PW + 1;
  localparam int HW = SW - (TRIG_W - 1);
  localparam logic signed [SW-1:0] HALF  = SW'(2 ** (TRIG_W - 2));
  localparam logic signed [HW-1:0] AMP_H = HW'(2 ** (TRIG_W - 1) - 1);

  logic signed [PW-1:0] p_sc, p_cs, p_cc, p_ss;
  logic signed [SW-1:0] sum_s, sum_c, rnd_s, rnd_c;

  always_ff @(posedge clk) begin
    if (en) begin
      p_sc <= sin_a * cos_d;
      p_cs <= cos_a * sin_d;
      p_cc <= cos_a * cos_d;
      p_ss <= sin_a * sin_d;
    end
  end

  function automatic logic signed [TRIG_W-1:0] clamp(input logic signed [HW-1:0] v);
    if (v > AMP_H)       return AMP_H[TRIG_W-1:0];
    else if (v < -AMP_H) return TRIG_W'(-AMP_H);
    else                 return v[TRIG_W-1:0];
  endfunction

  always_comb begin
    sum_s = p_sc + p_cs;
    sum_c = p_cc - p_ss;
    rnd_s = sum_s + HALF;
    rnd_c = sum_c + HALF;
  end

  logic unused_frac;
  assign unused_frac = ^{rnd_s[TRIG_W-2:0], rnd_c[TRIG_W-2:0]};

  always_ff @(posedge clk) begin
    if (en) begin
      sin_o <= clamp($signed(rnd_s[SW-1:TRIG_W-1]));
      cos_o <= clamp($signed(rnd_c[SW-1:TRIG_W-1]));
    end
  end

endmodule

// File: rtl/scm_mix_lane.sv
`timescale 1ns/1ps
// One output lane: sample times (optionally negated) trig value, rounded.
module scm_mix_lane #(
  parameter int SAMPLE_W = 16,
  parameter int TRIG_W   = 18,
  parameter bit NEG      = 1'b0
) (
  input  logic                       clk,
  input  logic                       en,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [TRIG_W-1:0]   trig,
  output logic signed [SAMPLE_W:0]   out_o
);
  localparam int MW    = SAMPLE_W + TRIG_W;
  localparam int OUT_W = SAMPLE_W + 1;
  localparam logic signed [MW-1:0] HALF = MW'(2 ** (TRIG_W - 2));

  logic signed [TRIG_W-1:0] tval;
  logic signed [MW-1:0]     prod, rnd;

  always_comb begin
    tval = NEG ? -trig : trig;
    prod = sample * tval;
    rnd  = prod + HALF;
  end

  logic unused_frac;
  assign unused_frac = ^rnd[TRIG_W-2:0];

  always_ff @(posedge clk) begin
    if (en) out_o <= rnd[TRIG_W-1 +: OUT_W];
  end

endmodule

// File: rtl/scm_mixer.sv
`timescale 1ns/1ps
module scm_mixer #(
  parameter int OCT_AW   = 9,
  parameter int FINE_W   = 9,
  parameter int PHASE_W  = 24,
  parameter int SAMPLE_W = 16,
  parameter int TRIG_W   = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [PHASE_W-1:0]         in_phase,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic signed [SAMPLE_W:0]   out_i,
  output logic signed [SAMPLE_W:0]   out_q
);
  localparam int COARSE_W = 3 + OCT_AW;
  localparam int USED_W   = COARSE_W + FINE_W;
  localparam int LOW_W    = PHASE_W - USED_W;
  localparam int NLANE    = 2;

  // Global advance: every stage moves when the output slot frees up.
  logic en;
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  // Phase fields.
  logic [2:0]        oct;
  logic [OCT_AW-1:0] c_addr, rom_addr;
  logic [FINE_W-1:0] f_addr;

  assign oct      = in_phase[PHASE_W-1 -: 3];
  assign c_addr   = in_phase[PHASE_W-4 -: OCT_AW];
  assign f_addr   = in_phase[PHASE_W-4-OCT_AW -: FINE_W];
  assign rom_addr = oct[0] ? ~c_addr : c_addr;

  generate
    if (LOW_W > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^in_phase[LOW_W-1:0];
    end
  endgenerate

  // Valid pipeline: stage1 (tables), stage2 (products), stage3 (sums), output.
  logic v1, v2, v3;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; out_valid <= 1'b0;
    end else if (en) begin
      v1 <= in_valid; v2 <= v1; v3 <= v2; out_valid <= v3;
    end
  end

  // Side-band alignment with the table and product stages.
  logic [1:0]                 quad1;
  logic                       half1;
  logic signed [SAMPLE_W-1:0] x1, x2, x3;
  always_ff @(posedge clk) begin
    if (en) begin
      quad1 <= oct[2:1];
      half1 <= oct[0];
      x1    <= in_sample;
      x2    <= x1;
      x3    <= x2;
    end
  end

  // Two tables.
  logic signed [TRIG_W-1:0] rc_s, rc_c, sd, cd;

  scm_trig_rom #(
    .AW(OCT_AW), .TRIG_W(TRIG_W), .DEN_LOG2(COARSE_W), .OFS(0.5)
  ) u_coarse (
    .clk(clk), .en(en), .addr(rom_addr), .sin_o(rc_s), .cos_o(rc_c)
  );

  scm_trig_rom #(
    .AW(FINE_W), .TRIG_W(TRIG_W), .DEN_LOG2(USED_W),
    .OFS(-real'(2 ** (FINE_W - 1)))
  ) u_fine (
    .clk(clk), .en(en), .addr(f_addr), .sin_o(sd), .cos_o(cd)
  );

  logic signed [TRIG_W-1:0] sa, ca;
  scm_octant_map #(.TRIG_W(TRIG_W)) u_map (
    .quad(quad1), .half(half1), .rom_s(rc_s), .rom_c(rc_c),
    .sin_o(sa), .cos_o(ca)
  );

  logic signed [TRIG_W-1:0] sin_t, cos_t;
  scm_angle_sum #(.TRIG_W(TRIG_W)) u_sum (
    .clk(clk), .en(en),
    .sin_a(sa), .cos_a(ca), .sin_d(sd), .cos_d(cd),
    .sin_o(sin_t), .cos_o(cos_t)
  );

  // Lane 0: x*cos -> I, lane 1: -x*sin -> Q.
  logic signed [TRIG_W-1:0] lane_trig [NLANE];
  logic signed [SAMPLE_W:0] lane_out  [NLANE];
  assign lane_trig[0] = cos_t;
  assign lane_trig[1] = sin_t;

  generate
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
      scm_mix_lane #(
        .SAMPLE_W(SAMPLE_W), .TRIG_W(TRIG_W), .NEG(g == 1)
      ) u_lane (
        .clk(clk), .en(en), .sample(x3), .trig(lane_trig[g]), .out_o(lane_out[g])
      );
    end
  endgenerate

  assign out_i = lane_out[0];
  assign out_q = lane_out[1];

endmodule

// File: rtl/scm_mixer_check.sv
`timescale 1ns/1ps
module scm_mixer_check #(
  parameter int SAMPLE_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic signed [SAMPLE_W:0] out_i,
  input logic signed [SAMPLE_W:0] out_q
);
  logic acc, emit;
  logic [3:0] occ;
  assign acc  = in_valid && in_ready;
  assign emit = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + 4'(acc) - 4'(emit);
  end

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc, 4) && $past(out_ready, 3) && $past(out_ready, 2) && $past(out_ready, 1)
    |-> out_valid);

  a_r5_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r5_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q));

  a_r7_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 4'd4);

  a_r7_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ != 4'd0);

endmodule

bind scm_mixer scm_mixer_check #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
);

// File: tb/scm_mixer_test.sv
`timescale 1ns/1ps
module scm_mixer_test;
  localparam int OCT_AW   = 4;
  localparam int FINE_W   = 4;
  localparam int PHASE_W  = 13;
  localparam int SAMPLE_W = 12;
  localparam int TRIG_W   = 16;
  localparam int USED_W   = 3 + OCT_AW + FINE_W;
  localparam int LOW_W    = PHASE_W - USED_W;
  localparam real TWO_PI  = 6.283185307179586;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [PHASE_W-1:0] in_phase = '0;
  logic signed [SAMPLE_W-1:0] in_sample = '0;
  logic signed [SAMPLE_W:0] out_i, out_q;

  int n_checks = 0, n_fail = 0;
  logic [PHASE_W-1:0]         q_phase [$];
  logic signed [SAMPLE_W-1:0] q_samp  [$];

  always #10 clk = ~clk;

  scm_mixer #(
    .OCT_AW(OCT_AW), .FINE_W(FINE_W), .PHASE_W(PHASE_W),
    .SAMPLE_W(SAMPLE_W), .TRIG_W(TRIG_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .in_sample(in_sample), .out_valid(out_valid),
    .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  task automatic check_bit(input string req, input string what, input logic got, input logic expv);
    n_checks++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, expv);
    end
  endtask

  task automatic check_near(input string req, input string what, input int got, input real expv);
    real d;
    n_checks++;
    d = real'(got) - expv;
    if (d > 2.0 || d < -2.0) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %f", req, what, got, expv);
    end
  endtask

  function automatic logic signed [SAMPLE_W-1:0] sample_for(input int n);
    case (n % 7)
      0: return 12'sd2047;
      1: return -12'sd2048;
      2: return 12'sd1234;
      3: return -12'sd777;
      4: return 12'sd1;
      5: return 12'sd0;
      default: return -12'sd1;
    endcase
  endfunction

  // Compare one output beat against the oldest accepted input (R1, R2, R3, R7).
  task automatic score(input bit tag_low);
    logic [PHASE_W-1:0] p;
    logic signed [SAMPLE_W-1:0] x;
    real th, ei, eq;
    if (q_phase.size() == 0) begin
      n_checks++; n_fail++;
      $display("FAIL R7 output without input: actual 1 expected 0");
      return;
    end
    p = q_phase.pop_front();
    x = q_samp.pop_front();
    th = TWO_PI * real'(p >> LOW_W) / (2.0 ** USED_W);
    ei = real'(x) * $cos(th);
    eq = -real'(x) * $sin(th);
    check_near((tag_low && p[LOW_W-1:0] != 0) ? "R1" : "R2",
               $sformatf("I phase=%0d x=%0d", p, x), int'(out_i), ei);
    check_near("R3", $sformatf("Q phase=%0d x=%0d", p, x), int'(out_q), eq);
  endtask

  task automatic stream(input int count, input bit rnd_hs);
    int sent = 0, idle = 0;
    logic [15:0] lf = 16'hACE1;
    bit acc = 1'b0, held = 1'b0;
    logic signed [SAMPLE_W:0] hi = '0, hq = '0;
    while (sent < count || q_phase.size() != 0) begin
      @(negedge clk);
      if (held) begin
        check_bit("R6", "valid held", out_valid, 1'b1);
        check_bit("R6", "I held", out_i == hi, 1'b1);
        check_bit("R6", "Q held", out_q == hq, 1'b1);
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      out_ready = rnd_hs ? (lf[0] | lf[3]) : 1'b1;
      if (!in_valid || acc) begin
        if (sent < count) begin
          in_valid  = rnd_hs ? (lf[5] | lf[7]) : 1'b1;
          in_phase  = rnd_hs ? PHASE_W'(sent * 37 + 11) : PHASE_W'(sent);
          in_sample = sample_for(sent + (rnd_hs ? 3 : 0));
        end else begin
          in_valid = 1'b0;
        end
      end
      #1;
      check_bit("R5", "in_ready", in_ready, !out_valid || out_ready);
      acc = in_valid && in_ready;
      if (acc) begin
        q_phase.push_back(in_phase);
        q_samp.push_back(in_sample);
        sent++;
      end
      if (out_valid && out_ready) begin
        score(!rnd_hs);
        idle = 0;
      end else if (q_phase.size() != 0) begin
        idle++;
      end
      held = out_valid && !out_ready;
      hi = out_i;
      hq = out_q;
      if (idle > 60) begin
        n_checks++; n_fail++;
        $display("FAIL R7 lost beats: actual %0d outstanding expected 0", q_phase.size());
        q_phase.delete(); q_samp.delete();
        break;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (6) begin
      @(negedge clk);
      check_bit("R7", "no extra output", out_valid, 1'b0);
    end
  endtask

  initial begin
    int lat;
    // R8: reset state, with the consumer not ready.
    repeat (3) @(negedge clk);
    check_bit("R8", "out_valid in reset", out_valid, 1'b0);
    check_bit("R8", "in_ready in reset", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R8", "out_valid after reset", out_valid, 1'b0);
    check_bit("R8", "in_ready after reset", in_ready, 1'b1);

    // R1/R2/R3/R5: every phase word, full throughput.
    stream(1 << PHASE_W, 1'b0);
    // R5/R6/R7: gaps on both handshakes.
    stream(2500, 1'b1);

    // R4: latency of a single beat.
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_phase  = PHASE_W'(1100);
    in_sample = 12'sd1500;
    #1;
    check_bit("R4", "accept", in_ready, 1'b1);
    q_phase.push_back(in_phase);
    q_samp.push_back(in_sample);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 8) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    n_checks++;
    if (lat != 3) begin
      n_fail++;
      $display("FAIL R4 latency: actual %0d expected 3", lat);
    end
    if (out_valid) score(1'b0);
    @(negedge clk);
    check_bit("R7", "single beat drained", out_valid, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule